// File: doc/BRIEF.md
# Fail-First Element Loop Controller

This block steps through the elements of a vector operation one at a time, strictly in index order, for an external element datapath. For each element it presents the element index and the number of the condition field that this element's condition result must be written to. Element zero targets the base field given at start, and each later element targets the next field along. After an element has been handed over, the datapath returns two flags: whether the data-dependent test on the result came out true, and whether the element faulted.

When either flag is set, the vector length is cut down to the index of that element and no further elements are issued. A fault therefore ends the loop like a true test would, and no exception is raised. Because only one element is ever in flight, no element beyond the cut point is ever started. If no element fails, the length stays as it was loaded. In both cases a one-cycle done pulse marks the end, and the final length stays on its output until the next loop completes.

Element issue and the return of results both use valid/ready handshakes. The controller holds `iss_valid`, `iss_idx` and `iss_field` steady until the datapath accepts them with `iss_ready`. The datapath may hold back its response for as long as it needs. The controller raises `rsp_ready` only while it is waiting for the result of the element it issued last. Start, length, base field, done and final length are plain control pins.

Top module: `ffirst_loop_ctrl`

## Requirements
- R1: After reset, `iss_valid`, `rsp_ready` and `done` are low and `final_len` is 0.
- R2: A start with length 0 issues no element. `done` pulses in the cycle after the start, with `final_len` = 0.
- R3: Elements are issued with indices 0, 1, 2 and so on. A new element is offered only after the response for the previous one has been accepted, so `iss_valid` and `rsp_ready` are never high together.
- R4: `iss_field` equals (base field + element index) modulo 128, on 7 bits.
- R5: While `iss_valid` is high and `iss_ready` is low, `iss_valid`, `iss_idx` and `iss_field` stay unchanged.
- R6: `rsp_ready` is high only between the acceptance of an element and the acceptance of its response.
- R7: A response with `rsp_test` or `rsp_fault` high for element i ends the loop. `done` pulses in the next cycle with `final_len` = i, and no further element is issued. When i = 0 the final length is 0.
- R8: If no response fails, `done` pulses in the cycle after the response for element L-1 is accepted, with `final_len` = L.
- R9: A start that arrives while a loop is running is ignored. The running loop keeps its length and base field.
- R10: A start length above MAX_LEN (64 by default) is clamped to MAX_LEN.
- R11: `done` is high for exactly one cycle, and `final_len` holds its value until the next loop completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a loop; taken only while idle |
| start_len | input | 7 | Requested vector length |
| start_field | input | 7 | Condition field for element 0 |
| iss_valid | output | 1 | An element is offered |
| iss_ready | input | 1 | Datapath accepts the element |
| iss_idx | output | 6 | Index of the offered element |
| iss_field | output | 7 | Destination condition field of the element |
| rsp_valid | input | 1 | Datapath returns a result |
| rsp_ready | output | 1 | Controller awaits a result |
| rsp_test | input | 1 | Data-dependent test was true |
| rsp_fault | input | 1 | Element faulted |
| done | output | 1 | One-cycle end-of-loop pulse |
| final_len | output | 7 | Vector length after truncation |

## Verification
The assertions assume that the datapath honours the handshake. `rsp_valid` is taken to matter only while `rsp_ready` is high, and the test and fault flags are taken to be meaningful only in the cycle of the response handshake. The bench's driver raises `iss_ready` only against a visible `iss_valid` and `rsp_valid` only against a visible `rsp_ready`, and it drives the flags only alongside `rsp_valid`. With the stall option, it inserts idle cycles on both channels so that the hold and wait paths are exercised without breaking these rules.

// File: rtl/ffl_pkg.sv
package ffl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } ffl_state_e;
endpackage

// File: rtl/ffl_len_latch.sv
module ffl_len_latch #(
  parameter int MAX_LEN = 64,
  parameter int LEN_W   = 7,
  parameter int FIELD_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [LEN_W-1:0]   in_len,
  input  logic [FIELD_W-1:0] in_base,
  output logic [LEN_W-1:0]   len_q,
  output logic [FIELD_W-1:0] base_q,
  output logic               len_zero
);
  localparam logic [LEN_W-1:0] LIMIT = LEN_W'(MAX_LEN);

  logic [LEN_W-1:0] clamped;

  always_comb begin
    clamped  = (in_len > LIMIT) ? LIMIT : in_len;
    len_zero = (clamped == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      base_q <= '0;
    end else if (load) begin
      len_q  <= clamped;
      base_q <= in_base;
    end
  end

  // R10: a loaded length never exceeds the limit
  a_r10_len_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (len_q <= LIMIT));
endmodule

// File: rtl/ffl_elem_ctr.sv
module ffl_elem_ctr #(
  parameter int IDX_W = 6,
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic [LEN_W-1:0] len_q,
  output logic [IDX_W-1:0] idx,
  output logic             last
);
  always_comb last = (LEN_W'(idx) == (len_q - LEN_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   idx <= '0;
    else if (clr) idx <= '0;
    else if (inc) idx <= idx + IDX_W'(1);
  end

  // R8: the counter never steps beyond the final element
  a_r8_no_step_past_end: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> !last);
  // R3: indices advance by one per step
  a_r3_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |=> (idx == $past(idx) + IDX_W'(1)));
endmodule

// File: rtl/ffl_field_gen.sv
module ffl_field_gen #(
  parameter int IDX_W   = 6,
  parameter int FIELD_W = 7
) (
  input  logic [FIELD_W-1:0] base,
  input  logic [IDX_W-1:0]   idx,
  output logic [FIELD_W-1:0] field
);
  localparam int SUM_W = FIELD_W + IDX_W;

  logic [SUM_W-1:0] sum;

  always_comb begin
    sum   = SUM_W'(base) + SUM_W'(idx);
    field = sum[FIELD_W-1:0];
  end
endmodule

// File: rtl/ffl_seq_fsm.sv
module ffl_seq_fsm
  import ffl_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             len_zero,
  input  logic [LEN_W-1:0] len_q,
  input  logic [IDX_W-1:0] idx,
  input  logic             last,
  input  logic             iss_ready,
  input  logic             rsp_valid,
  input  logic             rsp_test,
  input  logic             rsp_fault,
  output logic             load,
  output logic             inc,
  output logic             iss_valid,
  output logic             rsp_ready,
  output logic             done,
  output logic [LEN_W-1:0] fin_len
);
  ffl_state_e st;
  logic       fail;
  logic       rsp_hs;

  always_comb begin
    load      = start && (st == ST_IDLE);
    iss_valid = (st == ST_ISSUE);
    rsp_ready = (st == ST_WAIT);
    fail      = rsp_test || rsp_fault;
    rsp_hs    = rsp_ready && rsp_valid;
    inc       = rsp_hs && !fail && !last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      done    <= 1'b0;
      fin_len <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (load) begin
            if (len_zero) begin
              done    <= 1'b1;
              fin_len <= '0;
            end else begin
              st <= ST_ISSUE;
            end
          end
        end
        ST_ISSUE: begin
          if (iss_ready) st <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rsp_valid) begin
            if (fail) begin
              fin_len <= LEN_W'(idx);
              done    <= 1'b1;
              st      <= ST_IDLE;
            end else if (last) begin
              fin_len <= len_q;
              done    <= 1'b1;
              st      <= ST_IDLE;
            end else begin
              st <= ST_ISSUE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  a_r3_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    !(iss_valid && rsp_ready));
  a_r5_issue_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready) |=> (iss_valid && $stable(idx)));
  a_r6_wait_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready) |=> rsp_ready);
  a_r7_truncate: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hs && fail) |=> (done && !iss_valid && fin_len == LEN_W'($past(idx))));
  a_r8_full_length: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hs && !fail && last) |=> (done && fin_len == $past(len_q)));
  a_r2_empty_loop: assert property (@(posedge clk) disable iff (!rst_n)
    (load && len_zero) |=> (done && !iss_valid && fin_len == '0));
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r11_final_held: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(fin_len));
endmodule

// File: rtl/ffirst_loop_ctrl.sv
module ffirst_loop_ctrl #(
  parameter int MAX_LEN = 64,
  parameter int FIELD_W = 7,
  localparam int LEN_W  = $clog2(MAX_LEN + 1),
  localparam int IDX_W  = $clog2(MAX_LEN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [LEN_W-1:0]   start_len,
  input  logic [FIELD_W-1:0] start_field,
  output logic               iss_valid,
  input  logic               iss_ready,
  output logic [IDX_W-1:0]   iss_idx,
  output logic [FIELD_W-1:0] iss_field,
  input  logic               rsp_valid,
  output logic               rsp_ready,
  input  logic               rsp_test,
  input  logic               rsp_fault,
  output logic               done,
  output logic [LEN_W-1:0]   final_len
);
  logic               load, inc, len_zero, last;
  logic [LEN_W-1:0]   len_q;
  logic [FIELD_W-1:0] base_q;

  ffl_len_latch #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .FIELD_W(FIELD_W)) len_i (
    .clk(clk), .rst_n(rst_n), .load(load), .in_len(start_len),
    .in_base(start_field), .len_q(len_q), .base_q(base_q), .len_zero(len_zero)
  );

  ffl_elem_ctr #(.IDX_W(IDX_W), .LEN_W(LEN_W)) ctr_i (
    .clk(clk), .rst_n(rst_n), .clr(load), .inc(inc), .len_q(len_q),
    .idx(iss_idx), .last(last)
  );

  ffl_field_gen #(.IDX_W(IDX_W), .FIELD_W(FIELD_W)) fld_i (
    .base(base_q), .idx(iss_idx), .field(iss_field)
  );

  ffl_seq_fsm #(.IDX_W(IDX_W), .LEN_W(LEN_W)) fsm_i (
    .clk(clk), .rst_n(rst_n), .start(start), .len_zero(len_zero),
    .len_q(len_q), .idx(iss_idx), .last(last), .iss_ready(iss_ready),
    .rsp_valid(rsp_valid), .rsp_test(rsp_test), .rsp_fault(rsp_fault),
    .load(load), .inc(inc), .iss_valid(iss_valid), .rsp_ready(rsp_ready),
    .done(done), .fin_len(final_len)
  );
endmodule

// File: tb/ffirst_loop_ctrl_tb.sv
module ffirst_loop_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [6:0] start_len = '0;
  logic [6:0] start_field = '0;
  logic       iss_valid, iss_ready = 1'b0;
  logic [5:0] iss_idx;
  logic [6:0] iss_field;
  logic       rsp_valid = 1'b0, rsp_ready, rsp_test = 1'b0, rsp_fault = 1'b0;
  logic       done;
  logic [6:0] final_len;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  ffirst_loop_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_len(start_len),
    .start_field(start_field), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_idx(iss_idx), .iss_field(iss_field), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_test(rsp_test), .rsp_fault(rsp_fault),
    .done(done), .final_len(final_len)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired actual %0d cycles expected < 150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // entry: len[23:17] base[16:10] fail_idx[9:3] (127 = none) fault[2] stall[1] busy_start[0]
  localparam logic [23:0] VEC [10] = '{
    {7'd5,   7'd0,   7'd127, 1'b0, 1'b0, 1'b0},
    {7'd6,   7'd10,  7'd3,   1'b0, 1'b0, 1'b0},
    {7'd4,   7'd125, 7'd127, 1'b0, 1'b1, 1'b0},
    {7'd7,   7'd2,   7'd0,   1'b1, 1'b0, 1'b0},
    {7'd1,   7'd127, 7'd127, 1'b0, 1'b0, 1'b0},
    {7'd3,   7'd40,  7'd2,   1'b1, 1'b1, 1'b0},
    {7'd64,  7'd64,  7'd127, 1'b0, 1'b0, 1'b0},
    {7'd100, 7'd0,   7'd127, 1'b0, 1'b1, 1'b0},
    {7'd64,  7'd3,   7'd63,  1'b0, 1'b1, 1'b0},
    {7'd5,   7'd9,   7'd127, 1'b0, 1'b0, 1'b1}
  };

  task automatic run_loop(input int len, input int base, input int fidx,
                          input bit fault, input bit stall, input bit poke);
    int clen, exp_fin, exp_iss, exp_i, issued;
    bit finished;
    clen    = (len > 64) ? 64 : len;
    exp_fin = (fidx < clen) ? fidx : clen;
    exp_iss = (fidx < clen) ? fidx + 1 : clen;
    exp_i   = 0;
    issued  = 0;
    finished = 1'b0;
    @(negedge clk);
    start = 1'b1; start_len = 7'(len); start_field = 7'(base);
    @(negedge clk);
    start = 1'b0;
    for (int cyc = 0; cyc < 2000; cyc++) begin
      iss_ready = 1'b0; rsp_valid = 1'b0; rsp_test = 1'b0; rsp_fault = 1'b0;
      if (poke) start = (cyc == 2);
      if (poke && cyc == 2) begin start_len = 7'd2; start_field = 7'd100; end
      if (done) begin finished = 1'b1; break; end
      if (iss_valid) begin
        chk("R3 R5 element index", int'(iss_idx), exp_i);
        chk("R4 condition field", int'(iss_field), (base + exp_i) % 128);
        chk("R6 rsp_ready low while offering", int'(rsp_ready), 0);
        if (!stall || (cyc % 3 == 2)) begin
          iss_ready = 1'b1;
          issued = issued + 1;
        end
      end else if (rsp_ready) begin
        if (!stall || (cyc % 3 == 1)) begin
          rsp_valid = 1'b1;
          rsp_test  = !fault && (exp_i == fidx);
          rsp_fault = fault && (exp_i == fidx);
          exp_i = exp_i + 1;
        end
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk("R7 R8 loop finished", int'(finished), 1);
    chk(poke ? "R9 final length with busy start" :
        (fidx < clen ? "R7 truncated length" : "R8 full length"),
        int'(final_len), exp_fin);
    chk(len > 64 ? "R10 issues after clamp" : "R7 R8 issue count", issued, exp_iss);
    @(negedge clk);
    chk("R11 done pulse one cycle", int'(done), 0);
    chk("R11 final length held", int'(final_len), exp_fin);
    chk("R7 no issue after end", int'(iss_valid), 0);
  endtask

  initial begin
    #1;
    chk("R1 reset iss_valid", int'(iss_valid), 0);
    chk("R1 reset rsp_ready", int'(rsp_ready), 0);
    chk("R1 reset done", int'(done), 0);
    chk("R1 reset final_len", int'(final_len), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (VEC[k]) begin
      run_loop(int'(VEC[k][23:17]), int'(VEC[k][16:10]), int'(VEC[k][9:3]),
               VEC[k][2], VEC[k][1], VEC[k][0]);
    end

    // R2: zero-length loop
    @(negedge clk);
    start = 1'b1; start_len = 7'd0; start_field = 7'd5;
    @(negedge clk);
    start = 1'b0;
    chk("R2 done after empty start", int'(done), 1);
    chk("R2 final length zero", int'(final_len), 0);
    chk("R2 no element issued", int'(iss_valid), 0);
    @(negedge clk);
    chk("R2 R11 done drops", int'(done), 0);
    chk("R2 still no element", int'(iss_valid), 0);

    // R7: element 0 test failure after a full-length loop
    run_loop(8, 0, 127, 1'b0, 1'b0, 1'b0);
    run_loop(3, 20, 0, 1'b0, 1'b0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule